// File: doc/BRIEF.md
# Multi-mode programmable timer channel

This block is one general-purpose timer channel that shares a single external pin between three uses. In waveform mode it drives the pin with a repeating pulse whose period and high time come from programmable values. In pin-clocked mode the pin becomes the clock that advances the counter. In capture mode the block measures both the high time and the full period of a signal arriving on the pin.

Outside pin-clocked mode, the counter advances on a count tick. The tick comes from the system clock or from rising edges on one of two auxiliary clock inputs. The pin and both auxiliary clocks pass through two-flop synchronisers, and their edges are detected in the system-clock domain. A single-cycle interrupt pulse marks each counter wrap and each completed period capture. Software sets the configuration through a small write-only register port: control at address 0, period at address 1 and high time at address 2.

Top module: `gptmr_channel`

## Requirements
- R1: After reset, `pin_out`, `pin_oe`, `irq`, `count_o`, `cap_width_o` and `cap_period_o` are all zero.
- R2: The control word has enable in bit 0, mode in bits 2:1 (0 waveform, 1 pin-clocked, 2 capture, 3 idle) and tick source in bits 4:3. In waveform mode `pin_out` is high exactly while `count_o` is below the high-time value. On a tick, the counter returns to 0 when its incremented value reaches or passes the period. Otherwise it increments. Over any P consecutive ticks with period P, the pin is high for min(width, P) of them.
- R3: A high-time value of zero keeps `pin_out` low for the whole waveform.
- R4: `pin_oe` is 1 only when the channel is enabled in waveform mode. Otherwise the pin is released, and `pin_out` is 0.
- R5: In waveform and pin-clocked modes, `irq` is high for one cycle at each counter wrap.
- R6: In pin-clocked mode the counter advances once per rising edge of the pin, and the tick source field is ignored.
- R7: Tick source 0 gives one tick every system clock, 1 gives one tick per rising edge of `alt_clk_a`, 2 gives one per rising edge of `alt_clk_b`, and 3 gives no ticks.
- R8: In capture mode, a falling pin edge stores in `cap_width_o` the number of ticks since the preceding rising edge.
- R9: In capture mode, a rising edge that follows a falling edge stores in `cap_period_o` the ticks since the previous rising edge and pulses `irq` once. With the system tick, a pin held high for H cycles and then low for L cycles yields width H and period H+L.
- R10: The first rising pin edge after enable only arms capture. It pulses no `irq` and leaves `cap_period_o` unchanged.
- R11: A rising edge of enable clears the counter on the next cycle. While the channel is disabled, the counter holds and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 period, 2 high time |
| reg_wdata | input | CNT_W | Write data |
| pin_in | input | 1 | Level seen on the shared pin |
| alt_clk_a | input | 1 | First auxiliary count clock |
| alt_clk_b | input | 1 | Second auxiliary count clock |
| pin_out | output | 1 | Waveform driven onto the pin |
| pin_oe | output | 1 | Output enable for the pin |
| irq | output | 1 | One-cycle interrupt pulse |
| count_o | output | CNT_W | Current counter value |
| cap_width_o | output | CNT_W | Captured high time |
| cap_period_o | output | CNT_W | Captured period |

## Verification
The assertions assume that the pin and the auxiliary clocks stay at each level for at least one full system clock. Under that condition every transition yields exactly one detected edge, and a rising edge and a falling edge never land in the same cycle. The assertions also assume that a period or high-time write can leave the counter above a new period for a while, so none of them bounds the counter by the period. The stimulus drives all external levels on the falling clock edge and holds each one for at least two cycles. Each random period and width is followed by a settling interval before the waveform is measured.

// File: rtl/gptmr_pkg.sv
package gptmr_pkg;

    typedef enum logic [1:0] {
        MODE_WAVE    = 2'd0,
        MODE_PINCLK  = 2'd1,
        MODE_CAPTURE = 2'd2,
        MODE_IDLE    = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        SRC_SYS   = 2'd0,
        SRC_ALT_A = 2'd1,
        SRC_ALT_B = 2'd2,
        SRC_NONE  = 2'd3
    } tmr_src_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_WIDTH  = 2'd2;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MODE_LSB = 1;
    localparam int CTRL_SRC_LSB  = 3;

endpackage

// File: rtl/gptmr_regs.sv
module gptmr_regs
    import gptmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic             en,
    output tmr_mode_e        mode,
    output tmr_src_e         src,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] width
);

    typedef struct packed {
        logic             en;
        tmr_mode_e        mode;
        tmr_src_e         src;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] width;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (addr)
                ADDR_CTRL: begin
                    r_d.en   = wdata[CTRL_EN_BIT];
                    r_d.mode = tmr_mode_e'(wdata[CTRL_MODE_LSB +: 2]);
                    r_d.src  = tmr_src_e'(wdata[CTRL_SRC_LSB +: 2]);
                end
                ADDR_PERIOD: r_d.period = wdata;
                ADDR_WIDTH:  r_d.width  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{en: 1'b0, mode: MODE_WAVE, src: SRC_SYS,
                     period: '0, width: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign en     = r_q.en;
    assign mode   = r_q.mode;
    assign src    = r_q.src;
    assign period = r_q.period;
    assign width  = r_q.width;

endmodule

// File: rtl/gptmr_sync.sv
module gptmr_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stable;
        logic [N-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
        s_d.prev   = s_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] =  s_q.stable[i] & ~s_q.prev[i];
        assign fall[i] = ~s_q.stable[i] &  s_q.prev[i];
    end

endmodule

// File: rtl/gptmr_tick_sel.sv
module gptmr_tick_sel
    import gptmr_pkg::*;
(
    input  tmr_mode_e mode,
    input  tmr_src_e  src,
    input  logic      pin_rise,
    input  logic      alt_a_rise,
    input  logic      alt_b_rise,
    output logic      tick
);

    logic src_tick;

    always_comb begin
        unique case (src)
            SRC_SYS:   src_tick = 1'b1;
            SRC_ALT_A: src_tick = alt_a_rise;
            SRC_ALT_B: src_tick = alt_b_rise;
            default:   src_tick = 1'b0;
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_PINCLK:             tick = pin_rise;
            MODE_WAVE, MODE_CAPTURE: tick = src_tick;
            default:                 tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/gptmr_core.sv
module gptmr_core
    import gptmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] width,
    input  logic             tick,
    input  logic             pin_rise,
    input  logic             pin_fall,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_width,
    output logic [CNT_W-1:0] cap_period,
    output logic             irq,
    output logic             pin_out,
    output logic             pin_oe
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap_w;
        logic [CNT_W-1:0] cap_p;
        logic             irq;
        logic             en_prev;
        logic             armed;
        logic             fell;
    } core_t;

    core_t c_d, c_q;

    logic [CNT_W:0]   nxt_wide;
    logic             wrap;
    logic [CNT_W-1:0] meas;

    always_comb begin
        nxt_wide = {1'b0, c_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        wrap     = nxt_wide >= {1'b0, period};
        if (!tick) begin
            meas = c_q.cnt;
        end else if (c_q.cnt == CNT_MAX) begin
            meas = c_q.cnt;
        end else begin
            meas = nxt_wide[CNT_W-1:0];
        end
    end

    always_comb begin
        c_d         = c_q;
        c_d.irq     = 1'b0;
        c_d.en_prev = en;
        if (en && !c_q.en_prev) begin
            c_d.cnt   = '0;
            c_d.armed = 1'b0;
            c_d.fell  = 1'b0;
        end else if (en) begin
            unique case (mode)
                MODE_WAVE, MODE_PINCLK: begin
                    if (tick) begin
                        if (wrap) begin
                            c_d.cnt = '0;
                            c_d.irq = 1'b1;
                        end else begin
                            c_d.cnt = nxt_wide[CNT_W-1:0];
                        end
                    end
                end
                MODE_CAPTURE: begin
                    if (pin_rise) begin
                        if (c_q.armed && c_q.fell) begin
                            c_d.cap_p = meas;
                            c_d.irq   = 1'b1;
                        end
                        c_d.cnt   = '0;
                        c_d.armed = 1'b1;
                        c_d.fell  = 1'b0;
                    end else if (pin_fall && c_q.armed) begin
                        c_d.cap_w = meas;
                        c_d.fell  = 1'b1;
                        c_d.cnt   = meas;
                    end else begin
                        c_d.cnt = meas;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pin_oe     = en && (mode == MODE_WAVE);
    assign pin_out    = pin_oe && (c_q.cnt < width);
    assign count      = c_q.cnt;
    assign cap_width  = c_q.cap_w;
    assign cap_period = c_q.cap_p;
    assign irq        = c_q.irq;

endmodule

// File: rtl/gptmr_channel.sv
module gptmr_channel
    import gptmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic             pin_in,
    input  logic             alt_clk_a,
    input  logic             alt_clk_b,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cap_width_o,
    output logic [CNT_W-1:0] cap_period_o
);

    localparam int N_SYNC  = 3;
    localparam int IDX_PIN = 0;
    localparam int IDX_A   = 1;
    localparam int IDX_B   = 2;

    logic             ctrl_en;
    tmr_mode_e        ctrl_mode;
    tmr_src_e         ctrl_src;
    logic [CNT_W-1:0] ctrl_period;
    logic [CNT_W-1:0] ctrl_width;
    logic [N_SYNC-1:0] ext_rise;
    logic [N_SYNC-1:0] ext_fall;
    logic             pin_rise;
    logic             pin_fall;
    logic             tick;

    gptmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .en     (ctrl_en),
        .mode   (ctrl_mode),
        .src    (ctrl_src),
        .period (ctrl_period),
        .width  (ctrl_width)
    );

    gptmr_sync #(.N(N_SYNC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({alt_clk_b, alt_clk_a, pin_in}),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    assign pin_rise = ext_rise[IDX_PIN];
    assign pin_fall = ext_fall[IDX_PIN];

    gptmr_tick_sel u_tick (
        .mode       (ctrl_mode),
        .src        (ctrl_src),
        .pin_rise   (pin_rise),
        .alt_a_rise (ext_rise[IDX_A]),
        .alt_b_rise (ext_rise[IDX_B]),
        .tick       (tick)
    );

    gptmr_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctrl_en),
        .mode       (ctrl_mode),
        .period     (ctrl_period),
        .width      (ctrl_width),
        .tick       (tick),
        .pin_rise   (pin_rise),
        .pin_fall   (pin_fall),
        .count      (count_o),
        .cap_width  (cap_width_o),
        .cap_period (cap_period_o),
        .irq        (irq),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

endmodule

// File: rtl/gptmr_checker.sv
module gptmr_checker
    import gptmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cap_width,
    input logic             irq,
    input logic             pin_oe,
    input logic             pin_rise,
    input logic             pin_fall
);

    // R4: the pin is driven only in enabled waveform mode
    a_r4_oe_only_wave: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> (en && mode == MODE_WAVE));

    // R11: enable rising clears the counter one cycle later
    a_r11_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> (count == '0));

    // R11: a disabled channel keeps its count
    a_r11_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> $stable(count));

    // R6: in pin-clocked mode the counter only moves on a pin rising edge
    a_r6_pinclk_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(en, 2) && $past(mode == MODE_PINCLK) && !$stable(count))
        |-> $past(pin_rise));

    // R8: captured width changes only on a falling pin edge
    a_r8_width_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_width) |-> $past(pin_fall));

    // R9: a capture interrupt follows a rising pin edge
    a_r9_capture_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(mode == MODE_CAPTURE)) |-> $past(pin_rise));

endmodule

bind gptmr_channel gptmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_en),
    .mode      (ctrl_mode),
    .count     (count_o),
    .cap_width (cap_width_o),
    .irq       (irq),
    .pin_oe    (pin_oe),
    .pin_rise  (pin_rise),
    .pin_fall  (pin_fall)
);

// File: tb/tb_gptmr_channel.sv
module tb_gptmr_channel;

    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [1:0]       reg_addr = '0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic             pin_in = 1'b0;
    logic             alt_clk_a = 1'b0;
    logic             alt_clk_b = 1'b0;
    logic             pin_out, pin_oe, irq;
    logic [CNT_W-1:0] count_o, cap_width_o, cap_period_o;

    int n_chk  = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    int seed_dummy;

    gptmr_channel #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pin_in(pin_in), .alt_clk_a(alt_clk_a),
        .alt_clk_b(alt_clk_b), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
        .count_o(count_o), .cap_width_o(cap_width_o), .cap_period_o(cap_period_o)
    );

    always #5 clk = ~clk;

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycn(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq) irq_cnt++;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cycn(1);
        reg_we = 1'b0;
    endtask

    function automatic logic [CNT_W-1:0] ctl(input logic en, input logic [1:0] mode, input logic [1:0] src);
        return {{(CNT_W-5){1'b0}}, src, mode, en};
    endfunction

    function automatic int min_i(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic restart(input logic [1:0] mode, input logic [1:0] src);
        wr(2'd0, ctl(1'b0, mode, src));
        wr(2'd0, ctl(1'b1, mode, src));
    endtask

    // waveform measurement over 3 periods with system tick
    task automatic wave_meas(input int p, input int w);
        int highs, mism, irq0;
        wr(2'd1, p);
        wr(2'd2, w);
        cycn(2 * p + 4);
        highs = 0; mism = 0; irq0 = irq_cnt;
        for (int i = 0; i < 3 * p; i++) begin
            cycn(1);
            if (pin_out) highs++;
            if (pin_out != (count_o < w)) mism++;
        end
        check(highs == 3 * min_i(w, p), (w == 0) ? "R3" : "R2", highs, 3 * min_i(w, p));
        check(mism == 0, "R2", mism, 0);
        check(irq_cnt - irq0 == 3, "R5", irq_cnt - irq0, 3);
        check(pin_oe == 1'b1, "R4", pin_oe, 1);
    endtask

    task automatic alt_burst(input int n);
        for (int k = 0; k < n; k++) begin
            alt_clk_a = 1'b1; alt_clk_b = 1'b1; cycn(3);
            alt_clk_b = 1'b0; cycn(3);
            alt_clk_a = 1'b0; alt_clk_b = 1'b1; cycn(3);
            alt_clk_b = 1'b0; cycn(3);
        end
        cycn(4);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1-R11 run: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int c_hold, h, l, hn, ln, irq0;
        seed_dummy = $urandom(32'd1234);
        cycn(3);
        rst_n = 1'b1;
        cycn(2);

        // R1 reset state
        check(pin_out == 0 && pin_oe == 0, "R1", {pin_out, pin_oe}, 0);
        check(irq == 0 && count_o == 0, "R1", count_o, 0);
        check(cap_width_o == 0 && cap_period_o == 0, "R1", cap_period_o, 0);

        // R2 / R3 / R5 directed waveforms
        restart(2'd0, 2'd0);
        wave_meas(5, 2);
        wave_meas(5, 0);
        wave_meas(5, 7);
        wave_meas(1, 1);

        // R2 random waveforms
        for (int it = 0; it < 8; it++) begin
            wave_meas(1 + $urandom % 12, $urandom % 16);
        end

        // R7 tick source selection (A gets n edges, B gets 2n)
        wr(2'd1, 1000);
        wr(2'd2, 0);
        restart(2'd0, 2'd1);
        alt_burst(6);
        check(count_o == 6, "R7 alt A", count_o, 6);
        restart(2'd0, 2'd2);
        alt_burst(6);
        check(count_o == 12, "R7 alt B", count_o, 12);
        restart(2'd0, 2'd3);
        alt_burst(6);
        check(count_o == 0, "R7 none", count_o, 0);

        // R6 pin-clocked mode, source field ignored; R5 wraps; R4 released
        wr(2'd1, 4);
        restart(2'd1, 2'd3);
        irq0 = irq_cnt;
        for (int k = 0; k < 10; k++) begin
            pin_in = 1'b1; cycn(2);
            pin_in = 1'b0; cycn(2);
        end
        cycn(4);
        check(count_o == 2, "R6", count_o, 2);
        check(irq_cnt - irq0 == 2, "R5", irq_cnt - irq0, 2);
        check(pin_oe == 0 && pin_out == 0, "R4", {pin_oe, pin_out}, 0);

        // R8 / R9 / R10 capture with system tick
        restart(2'd2, 2'd0);
        irq0 = irq_cnt;
        h = 6; l = 5;
        pin_in = 1'b1; cycn(4);
        check(irq_cnt == irq0 && cap_period_o == 0, "R10", irq_cnt - irq0, 0);
        cycn(h - 4);
        pin_in = 1'b0; cycn(l);
        for (int k = 0; k < 6; k++) begin
            hn = 5 + $urandom % 10;
            ln = 2 + $urandom % 10;
            pin_in = 1'b1; cycn(4);
            check(cap_period_o == h + l, "R9", cap_period_o, h + l);
            check(cap_width_o == h, "R8", cap_width_o, h);
            check(irq_cnt - irq0 == k + 1, "R9 irq", irq_cnt - irq0, k + 1);
            cycn(hn - 4);
            pin_in = 1'b0; cycn(ln);
            h = hn; l = ln;
        end

        // R11 enable behaviour
        wr(2'd1, 50);
        wr(2'd2, 10);
        restart(2'd0, 2'd0);
        cycn(7);
        wr(2'd0, ctl(1'b0, 2'd0, 2'd0));
        cycn(2);
        c_hold = count_o;
        irq0 = irq_cnt;
        cycn(60);
        check(count_o == c_hold, "R11 hold", count_o, c_hold);
        check(irq_cnt == irq0, "R11 no irq", irq_cnt - irq0, 0);
        check(pin_oe == 0 && pin_out == 0, "R4", {pin_oe, pin_out}, 0);
        wr(2'd0, ctl(1'b1, 2'd0, 2'd0));
        cycn(1);
        check(count_o == 0, "R11 clear", count_o, 0);

        summary();
        $finish;
    end

endmodule